// File: doc/BRIEF.md
# Multi-Mode Timer Trio with Capture and Reload Partners

The block holds one 16-bit core timer and two 16-bit auxiliary timers. Each timer steps up or down according to its own mode. It can count prescaled clock ticks, count ticks only while its count pin sits at a chosen level, count rising edges of its count pin, or decode a quadrature pair presented on its count and direction pins. Every overflow or underflow of the core timer flips an output toggle latch and raises a one-cycle interrupt pulse.

Either auxiliary timer can also give up counting and serve the core timer. As a capture partner, it freezes and takes a copy of the core value on a rising edge of its own count pin. As a reload partner, it supplies a new start value to the core timer. The reload fires on a rising edge of the partner's count pin or on a chosen transition of the toggle latch. When one partner reloads on the latch going high and the other on the latch going low, the latch output becomes a free-running PWM wave, with the high and low times held in the two partners. A load port writes any timer directly and stands in for the control registers.

Top module: `mm_timer_trio`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three timer values, `tgl_out`, `core_irq` and `aux_irq` become 0.
- R2: In mode 0 (timer), a running timer steps once per prescaler tick. A tick occurs every 16·2^`presc_sel` clock cycles, starting from reset, so the factors run from 16 to 2048. A timer whose `run` bit is 0 holds its value.
- R3: In mode 1 (gated), a running timer steps on a prescaler tick only while its synchronized count pin equals its `gate_lvl` bit.
- R4: In mode 2 (counter), a running timer steps once per rising edge of its count pin. Pins pass through two synchronizing flip-flops and then an edge detector, so a pin change first moves the value on the third rising clock edge after it.
- R5: Outside mode 3, a timer counts down when `down` XOR (`dir_en` AND synchronized direction pin) is 1, and counts up otherwise.
- R6: In mode 3 (quadrature), with A on the count pin and B on the direction pin, a running timer steps once per edge of A or B. An edge of A counts up when A differs from B after the edge. An edge of B counts up when B equals A after the edge. All other single edges count down, and edges of A and B in the same cycle do not count.
- R7: Counting up from 0xFFFF gives 0, and counting down from 0 gives 0xFFFF. Each such wrap of the core timer inverts `tgl_out` and pulses `core_irq` high for one cycle.
- R8: Role 1 (capture) stops the auxiliary timer. A rising edge of its count pin copies the core value into it and pulses its `aux_irq` bit.
- R9: Role 2 (reload) stops the auxiliary timer and loads the core timer from it in place of the stepped value. Trigger code 0 reloads on a rising edge of the partner's count pin, 1 on the latch becoming 1, 2 on the latch becoming 0, and 3 on any latch change. The partner that reloads pulses its `aux_irq` bit, and auxiliary 0 wins when both fire.
- R10: An up-counting core with partner 0 on trigger 1 and partner 1 on trigger 2 gives a latch that stays high for 0x10000 minus partner 0's value in ticks, and low for 0x10000 minus partner 1's value.
- R11: A set `ld_en` bit writes `ld_data` into that timer and overrides stepping, capture and reload. A load of the core timer causes no wrap and no reload.
- R12: In role 0 or 3, an auxiliary timer runs on its own in its mode and pulses its `aux_irq` bit when it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Prescaler factor select, 16·2^n |
| mode_sel | input | 6 | Mode per timer, 2 bits each; core in [1:0] |
| run | input | 3 | Run enable per timer; bit 0 core |
| down | input | 3 | Down-count control bit per timer |
| dir_en | input | 3 | Lets the direction pin invert the count direction |
| gate_lvl | input | 3 | Active gate level per timer in mode 1 |
| aux_role | input | 4 | Role per auxiliary timer, 2 bits each |
| rl_trig | input | 4 | Reload trigger code per auxiliary timer |
| ld_en | input | 3 | Direct load strobe per timer |
| ld_data | input | 16 | Direct load value |
| cnt_pin | input | 3 | Count, gate or trigger pin per timer |
| dir_pin | input | 3 | Direction pin per timer |
| core_val | output | 16 | Core timer value |
| aux0_val | output | 16 | Auxiliary timer 0 value |
| aux1_val | output | 16 | Auxiliary timer 1 value |
| tgl_out | output | 1 | Core toggle latch |
| core_irq | output | 1 | Core wrap pulse |
| aux_irq | output | 2 | Auxiliary event pulses |

## Verification
The core timer is driven through each mode in turn. Prescaled ticks at several factors check the tick period. A gate pin that toggles slowly separates the level-sensitive mode from the edge-counting one. Pin bursts spaced a few cycles apart expose any error in synchronizer latency. Forward and reverse quadrature walks, followed by simultaneous A/B flips, tell the direction rule apart from a plain edge count. Loads just below the wrap points, pin-triggered captures and reloads, and the two-partner PWM setup show whether the latch edges, the reload priority and the stopped partners behave as specified.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_TIMER = 2'd0,
        MD_GATED = 2'd1,
        MD_COUNT = 2'd2,
        MD_QUAD  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        RL_RUN     = 2'd0,
        RL_CAPTURE = 2'd1,
        RL_RELOAD  = 2'd2,
        RL_RUN_ALT = 2'd3
    } aux_role_e;

    typedef enum logic [1:0] {
        TR_PIN        = 2'd0,
        TR_LATCH_RISE = 2'd1,
        TR_LATCH_FALL = 2'd2,
        TR_LATCH_ANY  = 2'd3
    } rl_trig_e;

    // synchronized pin level and its value one cycle earlier
    typedef struct packed {
        logic now;
        logic prev;
    } pin_evt_t;

    function automatic logic evt_rise(input pin_evt_t e);
        return e.now & ~e.prev;
    endfunction

    function automatic logic evt_edge(input pin_evt_t e);
        return e.now ^ e.prev;
    endfunction

endpackage

// File: rtl/tmr_pinsync.sv
module tmr_pinsync
    import tmr_pkg::*;
#(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   pin,
    output pin_evt_t       evt [N]
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[STAGES-1:0], pin[i]};
        end
        assign evt[i].now  = sh_q[STAGES-1];
        assign evt[i].prev = sh_q[STAGES];
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W     = 3,
    parameter int MIN_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = MIN_SHIFT + (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;

    always_comb begin
        mask = ~({CW{1'b1}} << (MIN_SHIFT + int'(sel)));
        tick = (cnt_q & mask) == mask;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_mode_e     mode,
    input  logic          run,
    input  logic          down,
    input  logic          dir_en,
    input  logic          gate_lvl,
    input  logic          tick,
    input  pin_evt_t      cnt_evt,
    input  pin_evt_t      dir_evt,
    input  logic [W-1:0]  cur,
    output logic [W-1:0]  nxt,
    output logic          wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic en, dn, a_edge, b_edge;

    always_comb begin
        a_edge = evt_edge(cnt_evt);
        b_edge = evt_edge(dir_evt);
        unique case (mode)
            MD_TIMER: en = run & tick;
            MD_GATED: en = run & tick & (cnt_evt.now == gate_lvl);
            MD_COUNT: en = run & evt_rise(cnt_evt);
            default:  en = run & (a_edge ^ b_edge);
        endcase
        if (mode == MD_QUAD)
            dn = a_edge ? (cnt_evt.now == dir_evt.now) : (dir_evt.now != cnt_evt.now);
        else
            dn = down ^ (dir_en & dir_evt.now);
        nxt  = cur;
        wrap = 1'b0;
        if (en) begin
            if (dn) begin
                nxt  = cur - ONE;
                wrap = (cur == '0);
            end else begin
                nxt  = cur + ONE;
                wrap = &cur;
            end
        end
    end

    // R6
    quad_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_QUAD && evt_edge(cnt_evt) && evt_edge(dir_evt)) |-> (nxt == cur));

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (nxt == cur && !wrap));
endmodule

// File: rtl/mm_timer_trio.sv
module mm_timer_trio
    import tmr_pkg::*;
#(
    parameter int W      = 16,
    parameter int SEL_W  = 3,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic [5:0]        mode_sel,
    input  logic [2:0]        run,
    input  logic [2:0]        down,
    input  logic [2:0]        dir_en,
    input  logic [2:0]        gate_lvl,
    input  logic [3:0]        aux_role,
    input  logic [3:0]        rl_trig,
    input  logic [2:0]        ld_en,
    input  logic [W-1:0]      ld_data,
    input  logic [2:0]        cnt_pin,
    input  logic [2:0]        dir_pin,
    output logic [W-1:0]      core_val,
    output logic [W-1:0]      aux0_val,
    output logic [W-1:0]      aux1_val,
    output logic              tgl_out,
    output logic              core_irq,
    output logic [1:0]        aux_irq
);
    localparam int NT = 3;
    localparam int NA = NT - 1;

    pin_evt_t   cevt [NT];
    pin_evt_t   devt [NT];
    logic       tick;
    logic [W-1:0] val_q [NT];
    logic [W-1:0] val_d [NT];
    logic [W-1:0] nxt   [NT];
    logic [NT-1:0] wrap;
    aux_role_e  role [NA];
    rl_trig_e   trig [NA];
    logic [NA-1:0] hit, sel, airq_d;
    logic       tgl_q, tgl_d, core_wrap, cirq_q;
    logic [NA-1:0] airq_q;

    tmr_pinsync #(.N(NT), .STAGES(SYNC)) u_csync (.clk(clk), .rst(rst), .pin(cnt_pin), .evt(cevt));
    tmr_pinsync #(.N(NT), .STAGES(SYNC)) u_dsync (.clk(clk), .rst(rst), .pin(dir_pin), .evt(devt));
    tmr_prescaler #(.SEL_W(SEL_W)) u_presc (.clk(clk), .rst(rst), .sel(presc_sel), .tick(tick));

    for (genvar i = 0; i < NT; i++) begin : g_step
        tmr_step #(.W(W)) u_step (
            .clk(clk), .rst(rst),
            .mode(tmr_mode_e'(mode_sel[2*i +: 2])),
            .run(run[i]), .down(down[i]), .dir_en(dir_en[i]), .gate_lvl(gate_lvl[i]),
            .tick(tick), .cnt_evt(cevt[i]), .dir_evt(devt[i]),
            .cur(val_q[i]), .nxt(nxt[i]), .wrap(wrap[i])
        );
    end

    for (genvar j = 0; j < NA; j++) begin : g_cfg
        assign role[j] = aux_role_e'(aux_role[2*j +: 2]);
        assign trig[j] = rl_trig_e'(rl_trig[2*j +: 2]);
    end

    always_comb begin
        core_wrap = wrap[0] & ~ld_en[0];
        tgl_d     = tgl_q ^ core_wrap;
        // reload requests, lowest index first
        for (int j = 0; j < NA; j++) begin
            hit[j] = 1'b0;
            if (role[j] == RL_RELOAD && !ld_en[0]) begin
                unique case (trig[j])
                    TR_PIN:        hit[j] = evt_rise(cevt[j+1]);
                    TR_LATCH_RISE: hit[j] = core_wrap & tgl_d;
                    TR_LATCH_FALL: hit[j] = core_wrap & ~tgl_d;
                    default:       hit[j] = core_wrap;
                endcase
            end
        end
        sel = '0;
        for (int j = NA - 1; j >= 0; j--) begin
            if (hit[j]) sel = NA'(1) << j;
        end
        val_d[0] = ld_en[0] ? ld_data : nxt[0];
        for (int j = 0; j < NA; j++) begin
            if (sel[j]) val_d[0] = val_q[j+1];
        end
        for (int j = 0; j < NA; j++) begin
            unique case (role[j])
                RL_CAPTURE: begin
                    airq_d[j]  = evt_rise(cevt[j+1]) & ~ld_en[j+1];
                    val_d[j+1] = airq_d[j] ? val_q[0] : val_q[j+1];
                end
                RL_RELOAD: begin
                    airq_d[j]  = sel[j];
                    val_d[j+1] = val_q[j+1];
                end
                default: begin
                    airq_d[j]  = wrap[j+1] & ~ld_en[j+1];
                    val_d[j+1] = nxt[j+1];
                end
            endcase
            if (ld_en[j+1]) val_d[j+1] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NT; i++) val_q[i] <= '0;
            tgl_q  <= 1'b0;
            cirq_q <= 1'b0;
            airq_q <= '0;
        end else begin
            for (int i = 0; i < NT; i++) val_q[i] <= val_d[i];
            tgl_q  <= tgl_d;
            cirq_q <= core_wrap;
            airq_q <= airq_d;
        end
    end

    assign core_val = val_q[0];
    assign aux0_val = val_q[1];
    assign aux1_val = val_q[2];
    assign tgl_out  = tgl_q;
    assign core_irq = cirq_q;
    assign aux_irq  = airq_q;

    // R7
    latch_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (tgl_out != $past(tgl_out)) |-> core_irq);

    // R7
    wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
        (core_wrap && sel == '0) |=> (core_val == '0 || core_val == '1));

    // R9
    reload_src_chk: assert property (@(posedge clk) disable iff (rst)
        sel[0] |=> (core_val == $past(aux0_val)));

    // R9
    reload_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(aux_irq & {role[1] == RL_RELOAD, role[0] == RL_RELOAD}));

    for (genvar j = 0; j < NA; j++) begin : g_hold_chk
        // R9
        partner_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (role[j] == RL_RELOAD && !ld_en[j+1]) |=> (val_q[j+1] == $past(val_q[j+1])));
    end
endmodule

// File: tb/test_mm_timer_trio.sv
module test_mm_timer_trio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  presc_sel = '0;
    logic [5:0]  mode_sel = '0;
    logic [2:0]  run = '0, down = '0, dir_en = '0, gate_lvl = '0, ld_en = '0;
    logic [2:0]  cnt_pin = '0, dir_pin = '0;
    logic [3:0]  aux_role = '0, rl_trig = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] core_val, aux0_val, aux1_val;
    logic        tgl_out, core_irq;
    logic [1:0]  aux_irq;

    always #4 clk = ~clk;

    mm_timer_trio i_mm_timer_trio (
        .clk(clk), .rst(rst), .presc_sel(presc_sel), .mode_sel(mode_sel),
        .run(run), .down(down), .dir_en(dir_en), .gate_lvl(gate_lvl),
        .aux_role(aux_role), .rl_trig(rl_trig), .ld_en(ld_en), .ld_data(ld_data),
        .cnt_pin(cnt_pin), .dir_pin(dir_pin),
        .core_val(core_val), .aux0_val(aux0_val), .aux1_val(aux1_val),
        .tgl_out(tgl_out), .core_irq(core_irq), .aux_irq(aux_irq)
    );

    // ---------------- reference model ----------------
    int  m_core, m_aux[2], m_tgl, m_cirq, m_airq[2];
    bit  c1[3], c2[3], c3[3], d1[3], d2[3], d3[3];
    int  pc;
    int  n_chk = 0, n_bad = 0, cycles = 0;
    bit  chk_on = 0;
    string cur_req = "R1";

    function automatic void mstep(input int i, input int cur, input bit tk,
                                  output int nv, output bit wr);
        bit en, dn, a, ap, b, bp, ea, eb;
        a = c2[i]; ap = c3[i]; b = d2[i]; bp = d3[i];
        ea = (a != ap); eb = (b != bp);
        case (mode_sel[2*i +: 2])
            2'd0:    en = run[i] && tk;
            2'd1:    en = run[i] && tk && (a == gate_lvl[i]);
            2'd2:    en = run[i] && a && !ap;
            default: en = run[i] && (ea != eb);
        endcase
        if (mode_sel[2*i +: 2] == 2'd3) dn = ea ? (a == b) : (b != a);
        else                             dn = down[i] ^ (dir_en[i] & b);
        nv = cur; wr = 0;
        if (en) begin
            if (dn) begin
                if (cur == 0) begin nv = 65535; wr = 1; end else nv = cur - 1;
            end else begin
                if (cur == 65535) begin nv = 0; wr = 1; end else nv = cur + 1;
            end
        end
    endfunction

    always @(posedge clk) begin
        int  nc, na[2], ntgl, picked, period, t, r;
        bit  tk, wc, wa, hit, rise;
        if (rst) begin
            m_core = 0; m_aux[0] = 0; m_aux[1] = 0; m_tgl = 0;
            m_cirq = 0; m_airq[0] = 0; m_airq[1] = 0; pc = 0;
            for (int i = 0; i < 3; i++) begin
                c1[i] = 0; c2[i] = 0; c3[i] = 0; d1[i] = 0; d2[i] = 0; d3[i] = 0;
            end
        end else begin
            period = 16 << presc_sel;
            tk = ((pc % period) == period - 1);
            mstep(0, m_core, tk, nc, wc);
            if (ld_en[0]) begin nc = ld_data; wc = 0; end
            ntgl = m_tgl ^ int'(wc);
            picked = -1;
            if (!ld_en[0]) begin
                for (int j = 0; j < 2; j++) begin
                    r = aux_role[2*j +: 2]; t = rl_trig[2*j +: 2];
                    rise = c2[j+1] && !c3[j+1];
                    if (t == 0)      hit = rise;
                    else if (t == 1) hit = wc && ntgl == 1;
                    else if (t == 2) hit = wc && ntgl == 0;
                    else             hit = wc;
                    if (picked < 0 && r == 2 && hit) picked = j;
                end
            end
            if (picked >= 0) nc = m_aux[picked];
            for (int j = 0; j < 2; j++) begin
                r = aux_role[2*j +: 2];
                rise = c2[j+1] && !c3[j+1];
                mstep(j + 1, m_aux[j], tk, na[j], wa);
                if (r == 1) begin
                    m_airq[j] = int'(rise && !ld_en[j+1]);
                    na[j] = (m_airq[j] != 0) ? m_core : m_aux[j];
                end else if (r == 2) begin
                    m_airq[j] = int'(picked == j);
                    na[j] = m_aux[j];
                end else begin
                    m_airq[j] = int'(wa && !ld_en[j+1]);
                end
                if (ld_en[j+1]) na[j] = ld_data;
            end
            m_core = nc; m_aux[0] = na[0]; m_aux[1] = na[1];
            m_tgl = ntgl; m_cirq = int'(wc);
            for (int i = 0; i < 3; i++) begin
                c3[i] = c2[i]; c2[i] = c1[i]; c1[i] = cnt_pin[i];
                d3[i] = d2[i]; d2[i] = d1[i]; d1[i] = dir_pin[i];
            end
            pc++;
        end
    end

    // ---------------- comparison every clock ----------------
    task automatic cmp(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            cmp("core_val", int'(core_val), m_core);
            cmp("aux0_val", int'(aux0_val), m_aux[0]);
            cmp("aux1_val", int'(aux1_val), m_aux[1]);
            cmp("tgl_out",  int'(tgl_out),  m_tgl);
            cmp("core_irq", int'(core_irq), m_cirq);
            cmp("aux_irq",  int'(aux_irq),  m_airq[1] * 2 + m_airq[0]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int idx, input logic [15:0] v);
        ld_data = v; ld_en = 3'b001 << idx; cyc(1); ld_en = '0;
    endtask

    task automatic pulse(input int idx, input int hi, input int lo);
        cnt_pin[idx] = 1'b1; cyc(hi); cnt_pin[idx] = 1'b0; cyc(lo);
    endtask

    task automatic quad(input bit fwd, input int n);
        for (int k = 0; k < n; k++) begin
            int s;
            s = fwd ? (k % 4) : ((4 - (k % 4)) % 4);
            case (s)
                0: begin cnt_pin[0] = 0; dir_pin[0] = 0; end
                1: begin cnt_pin[0] = 1; dir_pin[0] = 0; end
                2: begin cnt_pin[0] = 1; dir_pin[0] = 1; end
                default: begin cnt_pin[0] = 0; dir_pin[0] = 1; end
            endcase
            cyc(4);
        end
    endtask

    initial begin
        @(negedge clk);
        chk_on = 1;
        cur_req = "R1"; cyc(3);
        rst = 0;

        cur_req = "R2"; run = 3'b001; cyc(200);
        presc_sel = 3'd2; cyc(300);
        run = 3'b000; cyc(100);
        presc_sel = 3'd7; run = 3'b001; cyc(4200);
        presc_sel = 3'd0;

        cur_req = "R11"; load(0, 16'hFFF8);

        cur_req = "R7"; cyc(200);
        down[0] = 1'b1; cyc(300);
        down[0] = 1'b0;

        cur_req = "R5"; dir_en[0] = 1'b1; dir_pin[0] = 1'b1; cyc(120);
        dir_pin[0] = 1'b0; cyc(80);
        down[0] = 1'b1; cyc(80);
        down[0] = 1'b0; dir_en[0] = 1'b0;

        cur_req = "R3"; mode_sel[1:0] = 2'd1; gate_lvl[0] = 1'b1;
        for (int k = 0; k < 4; k++) pulse(0, 50, 70);
        gate_lvl[0] = 1'b0;
        for (int k = 0; k < 2; k++) pulse(0, 40, 60);

        cur_req = "R4"; mode_sel[1:0] = 2'd2; load(0, 16'hFFFC);
        for (int k = 0; k < 10; k++) pulse(0, 2, 3);
        for (int k = 0; k < 4; k++) pulse(0, 1, 1);
        down[0] = 1'b1;
        for (int k = 0; k < 8; k++) pulse(0, 3, 2);
        down[0] = 1'b0; cyc(6);

        cur_req = "R6"; mode_sel[1:0] = 2'd3; load(0, 16'h0003);
        quad(1'b1, 17); cnt_pin[0] = 0; dir_pin[0] = 0; cyc(6);
        quad(1'b0, 29); cnt_pin[0] = 0; dir_pin[0] = 0; cyc(6);
        for (int k = 0; k < 6; k++) begin
            cnt_pin[0] = ~cnt_pin[0]; dir_pin[0] = ~dir_pin[0]; cyc(5);
        end
        cnt_pin[0] = 0; dir_pin[0] = 0; cyc(6);
        mode_sel[1:0] = 2'd0;

        cur_req = "R12"; run = 3'b111; load(1, 16'hFFF4); load(2, 16'h0002);
        down[2] = 1'b1; cyc(400);
        down[2] = 1'b0;

        cur_req = "R8"; aux_role[1:0] = 2'd1; load(0, 16'h0100);
        cyc(40); pulse(1, 5, 60); pulse(1, 2, 90); pulse(1, 8, 20);
        load(1, 16'h1111); cyc(10);

        cur_req = "R9"; aux_role[1:0] = 2'd2; rl_trig[1:0] = 2'd0; load(1, 16'h1234);
        cyc(30); pulse(1, 4, 40);
        rl_trig[1:0] = 2'd1; load(1, 16'hFFF0); load(0, 16'hFFFA); cyc(700);
        aux_role = 4'b1010; rl_trig = 4'b1111; load(2, 16'hFF00); load(0, 16'hFFFC); cyc(200);
        rl_trig = 4'b1010; load(0, 16'hFFFE); cyc(200);

        cur_req = "R10"; aux_role = 4'b1010; rl_trig = 4'b1001;
        load(1, 16'hFFF4); load(2, 16'hFFFA); load(0, 16'hFFFF);
        cyc(2500);
        presc_sel = 3'd1; cyc(1500);

        cur_req = "R11"; ld_data = 16'hFFFF; ld_en = 3'b111; cyc(20); ld_en = '0; cyc(40);

        cur_req = "R1"; rst = 1'b1; cyc(3); rst = 1'b0; cyc(5);

        chk_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule